// File: doc/BRIEF.md
# Multichannel Serial Transmit Channel Gating

This block controls the transmit side of a time-division multiplexed serial port, one word slot at a time. A frame opens with a frame-sync pulse and then runs a fixed number of word slots, each counted as one channel. Every channel carries two independent controls: an enable bit and a mask bit. The enable bit decides whether the staged word in the holding register is copied into the shift register at the start of the slot. The mask bit decides whether the shifted bits actually reach the data pin, or whether the pin floats so that another device can drive a shared line.

A disabled channel counts as masked whatever its mask bit says. Because it never copies, it leaves the ready flag, the DMA request, the ready-driven interrupt and the empty flag alone. In symmetric mode the per-channel enables come from the receive channel selection vector instead of the transmit one, and the transmit mask still applies. The interrupt can follow each copy, or it can mark the end of each block of channels. The data pin is presented as a value plus an output-enable, and the pad's tri-state buffer sits outside this block.

Top module: `mctx_gate`

## Requirements
- R1: After reset, dx_oe_o, dx_o, dma_o and irq_o are 0, while ready_o and empty_o are 1.
- R2: A frame sync sampled high at a rising edge starts channel 0 at that edge. The channel index then advances every WORD_BITS clocks. After NUM_CH slots, dx_oe_o stays low until the next frame sync. A frame sync inside a frame restarts at channel 0.
- R3: Bit c of a channel vector belongs to channel c. An enabled channel copies the holding register into the shift register at the edge that starts its slot. A disabled channel makes no copy.
- R4: dx_oe_o is high for exactly the WORD_BITS cycles of a slot whose channel is enabled and has mask bit 0. It is low for masked channels. It is low for disabled channels whatever their mask bit.
- R5: While dx_oe_o is high, dx_o carries the copied word MSB first, one bit per clock, starting the cycle after the slot-start edge. While dx_oe_o is low, dx_o is 0.
- R6: A holding-register write clears ready_o from the next cycle, and a copy sets it. If a write and a copy fall on the same edge, ready_o becomes 0 and the copy takes the previous word.
- R7: dma_o pulses high for one cycle after each copy, and never for a disabled channel.
- R8: irq_mode_i = 2'b00 makes irq_o pulse exactly with dma_o. With 2'b01, irq_o pulses once after the last bit edge of every channel c where c mod BLOCK_CH = BLOCK_CH-1, and after the last channel, whether the channel is enabled or not. With 2'b10 or 2'b11, irq_o stays 0.
- R9: A copy clears empty_o. empty_o is set at the last bit edge of an enabled slot if ready_o was high and no copy happens on that edge. Disabled slots leave empty_o unchanged.
- R10: With sym_i = 1, rx_sel_i replaces ch_en_i as the per-channel enable, and ch_mask_i still gates the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one data bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | Frame-sync pulse, starts channel 0 |
| hold_wr_i | input | 1 | Write strobe for the holding register |
| hold_din_i | input | WORD_BITS | Word written into the holding register |
| ch_en_i | input | NUM_CH | Per-channel transmit enable |
| ch_mask_i | input | NUM_CH | Per-channel mask (1 = pin floats) |
| sym_i | input | 1 | Symmetric mode: take enables from rx_sel_i |
| rx_sel_i | input | NUM_CH | Receive channel selection |
| irq_mode_i | input | 2 | Interrupt source select |
| dx_o | output | 1 | Serial data value |
| dx_oe_o | output | 1 | Data pin output-enable |
| ready_o | output | 1 | Holding register may be written |
| empty_o | output | 1 | Shift register has no fresh word |
| dma_o | output | 1 | DMA request pulse on each copy |
| irq_o | output | 1 | Transmit interrupt pulse |

## Verification
Four directed frames come first. The first has every channel enabled and unmasked, which shows full-frame driving. The second has every channel disabled but unmasked, which shows that disable overrides the mask and that the flags stay silent. The third mixes enable and mask so that load-without-drive is told apart from drive. The fourth is a symmetric-mode frame in which the transmit enables are all zero, so any copy must come from the receive selection. Random frames then vary the enables, masks, mode, interrupt source and write timing, including writes on a slot-start edge and occasional restarts in mid-frame. These separate the write-versus-copy race and the empty-flag rules from the plain per-slot behaviour.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
  typedef enum logic [1:0] {
    IRQ_ON_COPY  = 2'b00,
    IRQ_ON_BLOCK = 2'b01,
    IRQ_NONE_A   = 2'b10,
    IRQ_NONE_B   = 2'b11
  } irq_src_e;
endpackage

// File: rtl/mctx_slot_timer.sv
module mctx_slot_timer #(
  parameter int WORD_BITS = 8,
  parameter int NUM_CH    = 4,
  parameter int BLOCK_CH  = 2,
  localparam int BW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync_i,
  output logic          live_o,
  output logic          start_o,
  output logic [CW-1:0] next_ch_o,
  output logic          slot_end_o,
  output logic          block_end_o
);
  logic [BW-1:0] bit_q;
  logic [CW-1:0] ch_q;
  logic          live_q;
  logic          word_last;
  logic          ch_last;

  assign word_last   = live_q && (bit_q == BW'(WORD_BITS - 1));
  assign ch_last     = (ch_q == CW'(NUM_CH - 1));
  assign start_o     = fsync_i || (word_last && !ch_last);
  assign next_ch_o   = fsync_i ? '0 : ch_q + 1'b1;
  assign slot_end_o  = word_last;
  assign block_end_o = word_last &&
                       (((int'(ch_q) % BLOCK_CH) == BLOCK_CH - 1) || ch_last);
  assign live_o      = live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      bit_q  <= '0;
      ch_q   <= '0;
    end else if (fsync_i) begin
      live_q <= 1'b1;
      bit_q  <= '0;
      ch_q   <= '0;
    end else if (live_q) begin
      if (word_last) begin
        bit_q <= '0;
        if (ch_last) live_q <= 1'b0;
        else         ch_q   <= ch_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mctx_ch_select.sv
module mctx_ch_select #(
  parameter int NUM_CH = 4,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  input  logic              sym_i,
  input  logic [NUM_CH-1:0] rx_sel_i,
  input  logic [CW-1:0]     idx_i,
  output logic              en_o,
  output logic              drive_o
);
  logic [NUM_CH-1:0] eff_en;
  logic [NUM_CH-1:0] eff_drv;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign eff_en[c]  = sym_i ? rx_sel_i[c] : ch_en_i[c];
    assign eff_drv[c] = eff_en[c] && !ch_mask_i[c];
  end

  assign en_o    = eff_en[idx_i];
  assign drive_o = eff_drv[idx_i];
endmodule

// File: rtl/mctx_tx_shifter.sv
module mctx_tx_shifter #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [WORD_BITS-1:0] din_i,
  input  logic                 live_i,
  input  logic                 start_i,
  input  logic                 slot_end_i,
  input  logic                 load_i,
  input  logic                 drive_i,
  output logic                 dx_o,
  output logic                 oe_o
);
  logic [WORD_BITS-1:0] hold_q;
  logic [WORD_BITS-1:0] sh_q;
  logic                 oe_q;

  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (wr_i) hold_q <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= hold_q;
    else if (live_i)  sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)             oe_q <= 1'b0;
    else if (start_i)    oe_q <= drive_i;
    else if (slot_end_i) oe_q <= 1'b0;
  end

  assign oe_o = oe_q;
  assign dx_o = oe_q && sh_q[WORD_BITS-1];
endmodule

// File: rtl/mctx_flags.sv
module mctx_flags
  import mctx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic       start_i,
  input  logic       load_i,
  input  logic       slot_end_i,
  input  logic       block_end_i,
  input  logic [1:0] irq_mode_i,
  output logic       ready_o,
  output logic       empty_o,
  output logic       dma_o,
  output logic       irq_o
);
  logic     ready_q, empty_q, dma_q, irq_q, cur_en_q;
  logic     irq_d;
  irq_src_e src;

  assign src = irq_src_e'(irq_mode_i);

  always_comb begin
    case (src)
      IRQ_ON_COPY:  irq_d = load_i;
      IRQ_ON_BLOCK: irq_d = block_end_i;
      default:      irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b1;
      empty_q  <= 1'b1;
      dma_q    <= 1'b0;
      irq_q    <= 1'b0;
      cur_en_q <= 1'b0;
    end else begin
      dma_q <= load_i;
      irq_q <= irq_d;
      if (wr_i)        ready_q <= 1'b0;
      else if (load_i) ready_q <= 1'b1;
      if (load_i)
        empty_q <= 1'b0;
      else if (slot_end_i && cur_en_q && ready_q)
        empty_q <= 1'b1;
      if (start_i)         cur_en_q <= load_i;
      else if (slot_end_i) cur_en_q <= 1'b0;
    end
  end

  assign ready_o = ready_q;
  assign empty_o = empty_q;
  assign dma_o   = dma_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/mctx_gate.sv
module mctx_gate #(
  parameter int WORD_BITS = 8,
  parameter int NUM_CH    = 4,
  parameter int BLOCK_CH  = 2,
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fsync_i,
  input  logic                 hold_wr_i,
  input  logic [WORD_BITS-1:0] hold_din_i,
  input  logic [NUM_CH-1:0]    ch_en_i,
  input  logic [NUM_CH-1:0]    ch_mask_i,
  input  logic                 sym_i,
  input  logic [NUM_CH-1:0]    rx_sel_i,
  input  logic [1:0]           irq_mode_i,
  output logic                 dx_o,
  output logic                 dx_oe_o,
  output logic                 ready_o,
  output logic                 empty_o,
  output logic                 dma_o,
  output logic                 irq_o
);
  logic          live, start, slot_end, block_end;
  logic [CW-1:0] next_ch;
  logic          ch_en, ch_drive, load;

  mctx_slot_timer #(.WORD_BITS(WORD_BITS), .NUM_CH(NUM_CH), .BLOCK_CH(BLOCK_CH)) u_timer (
    .clk(clk), .rst(rst), .fsync_i(fsync_i),
    .live_o(live), .start_o(start), .next_ch_o(next_ch),
    .slot_end_o(slot_end), .block_end_o(block_end)
  );

  mctx_ch_select #(.NUM_CH(NUM_CH)) u_sel (
    .ch_en_i(ch_en_i), .ch_mask_i(ch_mask_i), .sym_i(sym_i),
    .rx_sel_i(rx_sel_i), .idx_i(next_ch),
    .en_o(ch_en), .drive_o(ch_drive)
  );

  assign load = start && ch_en;

  mctx_tx_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk(clk), .rst(rst), .wr_i(hold_wr_i), .din_i(hold_din_i),
    .live_i(live), .start_i(start), .slot_end_i(slot_end),
    .load_i(load), .drive_i(ch_drive), .dx_o(dx_o), .oe_o(dx_oe_o)
  );

  mctx_flags u_flags (
    .clk(clk), .rst(rst), .wr_i(hold_wr_i), .start_i(start),
    .load_i(load), .slot_end_i(slot_end), .block_end_i(block_end),
    .irq_mode_i(irq_mode_i), .ready_o(ready_o), .empty_o(empty_o),
    .dma_o(dma_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/mctx_gate_chk.sv
module mctx_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold_wr_i,
  input logic [1:0] irq_mode_i,
  input logic       ready_o,
  input logic       empty_o,
  input logic       dma_o,
  input logic       irq_o
);
  AST_WR_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    hold_wr_i |=> !ready_o); // R6
  AST_COPY_RACE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (dma_o && !ready_o) |-> $past(hold_wr_i)); // R6
  AST_COPY_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dma_o |-> !empty_o); // R9
  AST_COPY_IRQ_TRACKS_DMA: assert property (@(posedge clk) disable iff (rst)
    (irq_mode_i == 2'b00) |=> (irq_o == dma_o)); // R8
  AST_IRQ_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    irq_mode_i[1] |=> !irq_o); // R8
endmodule

bind mctx_gate mctx_gate_chk u_chk (.*);

// File: tb/mctx_gate_tb.sv
module mctx_gate_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync_i = 1'b0, hold_wr_i = 1'b0, sym_i = 1'b0;
  logic [7:0] hold_din_i = '0;
  logic [3:0] ch_en_i = '0, ch_mask_i = '0, rx_sel_i = '0;
  logic [1:0] irq_mode_i = '0;
  logic dx_o, dx_oe_o, ready_o, empty_o, dma_o, irq_o;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  mctx_gate u_dut (.*);

  // bench-side expected state, as of the last rising edge
  logic       m_live, m_oe, m_ready, m_empty, m_dma, m_irq, m_curen;
  logic [2:0] m_bit;
  logic [1:0] m_ch;
  logic [7:0] m_sh, m_hold;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] eff_en(input logic s, input logic [3:0] e, input logic [3:0] r);
    return s ? r : e;
  endfunction

  task automatic model_step();
    logic [3:0] en;
    logic wl, last, st, ld, drv, blk, irqn;
    logic [1:0] nch;
    en   = eff_en(sym_i, ch_en_i, rx_sel_i);
    wl   = m_live && (m_bit == 3'd7);
    last = (m_ch == 2'd3);
    st   = fsync_i || (wl && !last);
    nch  = fsync_i ? 2'd0 : m_ch + 2'd1;
    ld   = st && en[nch];
    drv  = ld && !ch_mask_i[nch];
    blk  = wl && (m_ch[0] || last);
    case (irq_mode_i)
      2'b00:   irqn = ld;
      2'b01:   irqn = blk;
      default: irqn = 1'b0;
    endcase
    if (ld) m_empty = 1'b0;
    else if (wl && m_curen && m_ready) m_empty = 1'b1;
    if (hold_wr_i) m_ready = 1'b0; else if (ld) m_ready = 1'b1;
    if (ld) m_sh = m_hold; else if (m_live) m_sh = {m_sh[6:0], 1'b0};
    if (st) m_oe = drv; else if (wl) m_oe = 1'b0;
    if (st) m_curen = ld; else if (wl) m_curen = 1'b0;
    if (hold_wr_i) m_hold = hold_din_i;
    m_dma = ld;
    m_irq = irqn;
    if (fsync_i) begin
      m_live = 1'b1; m_bit = '0; m_ch = '0;
    end else if (m_live) begin
      if (wl) begin
        m_bit = '0;
        if (last) m_live = 1'b0; else m_ch = m_ch + 2'd1;
      end else m_bit = m_bit + 3'd1;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int frame = -1;
    int cnt_dma = 0, cnt_oe = 0;
    void'($urandom(32'h5EED_1234));
    m_live = 0; m_oe = 0; m_ready = 1; m_empty = 1; m_dma = 0; m_irq = 0;
    m_curen = 0; m_bit = '0; m_ch = '0; m_sh = '0; m_hold = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 oe", dx_oe_o, 1'b0);
    chk("R1 dx", dx_o, 1'b0);
    chk("R1 dma", dma_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 ready", ready_o, 1'b1);
    chk("R1 empty", empty_o, 1'b1);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      fsync_i = 1'b0;
      hold_wr_i = 1'b0;
      if ((!m_live && ($urandom % 3 == 0)) ||
          (frame >= 4 && m_live && ($urandom % 250 == 0))) begin
        // close out the previous directed frame
        if (frame == 0) begin
          chk_int("R2 driven bit times, full frame", cnt_oe, 32);
          chk_int("R3 copies, all enabled", cnt_dma, 4);
        end else if (frame == 1) begin
          chk_int("R4 driven bits, all disabled", cnt_oe, 0);
          chk_int("R3 copies, all disabled", cnt_dma, 0);
        end else if (frame == 2) begin
          chk_int("R4 driven bits, en 1010 mask 0110", cnt_oe, 8);
          chk_int("R3 copies, en 1010", cnt_dma, 2);
        end else if (frame == 3) begin
          chk_int("R10 copies from rx selection 0101", cnt_dma, 2);
          chk_int("R10 driven bits, mask 0100", cnt_oe, 8);
        end
        frame++;
        cnt_dma = 0; cnt_oe = 0;
        fsync_i = 1'b1;
        case (frame)
          0: begin ch_en_i = 4'b1111; ch_mask_i = 4'b0000; sym_i = 0; irq_mode_i = 2'b00; end
          1: begin ch_en_i = 4'b0000; ch_mask_i = 4'b0000; sym_i = 0; irq_mode_i = 2'b01; end
          2: begin ch_en_i = 4'b1010; ch_mask_i = 4'b0110; sym_i = 0; irq_mode_i = 2'b00; end
          3: begin ch_en_i = 4'b0000; ch_mask_i = 4'b0100; sym_i = 1; rx_sel_i = 4'b0101;
                   irq_mode_i = 2'b01; end
          default: begin
            ch_en_i = 4'($urandom); ch_mask_i = 4'($urandom); rx_sel_i = 4'($urandom);
            sym_i = ($urandom % 4 == 0); irq_mode_i = 2'($urandom);
          end
        endcase
      end
      if (frame < 4) hold_wr_i = m_live && (m_bit == 3'd2);
      else           hold_wr_i = ($urandom % 6 == 0);
      hold_din_i = 8'($urandom);
      model_step();
      @(negedge clk);
      cnt_dma += int'(dma_o);
      cnt_oe  += int'(dx_oe_o);
      chk("R4 output enable", dx_oe_o, m_oe);
      chk("R5 serial data", dx_o, m_oe ? m_sh[7] : 1'b0);
      chk("R6 ready", ready_o, m_ready);
      chk("R7 dma", dma_o, m_dma);
      chk("R8 irq", irq_o, m_irq);
      chk("R9 empty", empty_o, m_empty);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule